// File: doc/BRIEF.md
# Instruction Byte-Stream Predecoder

The predecoder sits between an instruction fetch unit and the decode stage of a 16-bit controller core. Code bytes arrive one at a time over a valid/ready input. The block groups them into whole instructions of two or four bytes and emits one record per instruction over a valid/ready output. A record holds the opcode, the length, the operand bytes, a coarse class and several side fields taken from the opcode and the first operand byte: a bit number, a jump condition index, an addressing sub-mode with its immediate or pointer value, and the kind of an extend/atomic prefix.

Undefined opcodes do not stop the stream. They produce a record with the trap flag set and a length of two, and decoding goes on with the byte after that pair. A flush pulse discards a partly collected instruction, so the next accepted byte is taken as an opcode. A finished record that is already waiting at the output is kept.

Back-pressure works as follows. A byte is taken on a rising edge only when `in_valid` and `in_ready` are both high. `in_ready` is low whenever a record is waiting and `out_ready` is low, and also during a flush cycle. A waiting record holds every output field unchanged until `out_ready` is seen high. No byte is dropped or counted twice.

Top module: `ibs_predecode`

## Requirements
- R1: For opcodes 00h-7Fh, `out_len` is 4 when the low nibble is 2, 3, 4, 5, 6, 7 or A, and 2 otherwise. 44h and 45h are exceptions: they are undefined and have length 2.
- R2: For opcodes 80h-FFh, `out_len` is 4 for exactly these opcodes: 82 84 86 87 8A 92 94 96 97 9A A2 A4 A5 A6 A7 AA B2 B4 B5 B6 B7 BA C2 C4 C5 C6 CA D2 D4 D5 D6 D7 DA E2 E4 E6 E7 EA F2 F3 F4 F6 F7 FA. Every other opcode in this range has length 2.
- R3: Opcodes 3B 44 45 83 85 8B 8C 93 95 A3 B3 C1 C3 C7 D3 E3 E5 F5 F8 F9 give a record with `out_trap`=1, length 2 and class 4. The next instruction starts two bytes after the undefined opcode.
- R4: An opcode with low nibble E or F has class 1 (bit clear/set), and `out_bitnum` equals its high nibble. For every other opcode `out_bitnum` is 0.
- R5: An opcode with low nibble D has class 2 (relative jump), and `out_cond` equals its high nibble (0 means unconditional). For every other opcode `out_cond` is 0.
- R6: For opcodes below 80h with low nibble 8 or 9, the low nibble of the first operand byte selects `out_amode`: values 0-7 give 1 (3-bit immediate), with `out_sub` equal to that value.
- R7: For the same opcodes, values 8-B give `out_amode` 2 (register-indirect) and values C-F give 3 (indirect with post-increment). In both cases `out_sub` equals the value's two low bits (pointer 0-3). For all other opcodes `out_amode` and `out_sub` are 0.
- R8: Opcodes D1, D7 and DC have class 3 (prefix), and `out_extkind` equals bits 7:6 of the first operand byte (0 segment/atomic, 1 page, 2 segment-or-register with register, 3 page with register). For all other opcodes `out_extkind` is 0.
- R9: A defined opcode below 80h with low nibble 0-9 has class 0 (arithmetic/logic). Any defined opcode not covered by R4, R5 or R8 has class 4.
- R10: `out_operand` holds operand byte 1 in bits 7:0, byte 2 in 15:8 and byte 3 in 23:16, with unused bytes 0. While `out_valid` is high and `out_ready` is low, all record outputs stay stable and `in_ready` is low. Every instruction yields exactly one record, in stream order.
- R11: While `flush` is high, `in_ready` is low. A partly received instruction is discarded, and the next accepted byte is decoded as an opcode.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard partial instruction, realign to next byte |
| in_valid | input | 1 | Code byte present |
| in_ready | output | 1 | Byte will be taken this cycle |
| in_byte | input | 8 | Code byte |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Opcode byte |
| out_len | output | 3 | Instruction length, 2 or 4 |
| out_operand | output | 24 | Operand bytes 1..3 |
| out_trap | output | 1 | Opcode is undefined |
| out_class | output | 3 | 0 arith/logic, 1 bit op, 2 jump, 3 prefix, 4 other |
| out_bitnum | output | 4 | Bit number of a bit clear/set |
| out_cond | output | 4 | Jump condition index |
| out_amode | output | 2 | 0 none, 1 imm3, 2 indirect, 3 indirect post-increment |
| out_sub | output | 3 | Immediate value or pointer index |
| out_extkind | output | 2 | Prefix sub-kind |

## Verification
Some properties are checked on every cycle: a stalled record keeps all its outputs and blocks input, flush blocks input, every record has a legal length, a trap record is two bytes long, and the bit, condition and prefix fields follow the opcode and operand byte whenever a record is valid. The following can only be shown by the bench's scenarios: correct alignment across a long stream, resumption after an undefined opcode, discarding on flush, the exact length and class of all 256 opcodes, and the absence of lost or duplicated records under irregular back-pressure. The bench checks these against a scoreboard that is filled from the opcode lists.

// File: rtl/ibs_pkg.sv
package ibs_pkg;
  localparam int BYTE_W  = 8;
  localparam int MAX_LEN = 4;
  localparam int OPND_W  = (MAX_LEN - 1) * BYTE_W;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int CNT_W   = $clog2(MAX_LEN);

  typedef enum logic [2:0] {
    CLS_ALU   = 3'd0,
    CLS_BIT   = 3'd1,
    CLS_JMP   = 3'd2,
    CLS_PFX   = 3'd3,
    CLS_OTHER = 3'd4
  } cls_e;

  typedef enum logic [1:0] {
    AM_NONE = 2'd0,
    AM_IMM  = 2'd1,
    AM_IND  = 2'd2,
    AM_INC  = 2'd3
  } amode_e;
endpackage

// File: rtl/ibs_len_map.sv
module ibs_len_map
  import ibs_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  output logic              long4,
  output logic              undef
);
  logic [3:0] nib;
  assign nib = op[3:0];

  always_comb begin
    long4 = 1'b0;
    undef = 1'b0;
    if (!op[BYTE_W-1]) begin
      unique case (nib)
        4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA: long4 = 1'b1;
        default: long4 = 1'b0;
      endcase
      if (op == 8'h3B || op == 8'h44 || op == 8'h45) undef = 1'b1;
    end else begin
      case (op)
        8'h82, 8'h84, 8'h86, 8'h87, 8'h8A, 8'h92, 8'h94, 8'h96, 8'h97,
        8'h9A, 8'hA2, 8'hA4, 8'hA5, 8'hA6, 8'hA7, 8'hAA, 8'hB2, 8'hB4,
        8'hB5, 8'hB6, 8'hB7, 8'hBA, 8'hC2, 8'hC4, 8'hC5, 8'hC6, 8'hCA,
        8'hD2, 8'hD4, 8'hD5, 8'hD6, 8'hD7, 8'hDA, 8'hE2, 8'hE4, 8'hE6,
        8'hE7, 8'hEA, 8'hF2, 8'hF3, 8'hF4, 8'hF6, 8'hF7, 8'hFA:
          long4 = 1'b1;
        8'h83, 8'h85, 8'h8B, 8'h8C, 8'h93, 8'h95, 8'hA3, 8'hB3, 8'hC1,
        8'hC3, 8'hC7, 8'hD3, 8'hE3, 8'hE5, 8'hF5, 8'hF8, 8'hF9:
          undef = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ibs_field_dec.sv
module ibs_field_dec
  import ibs_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  input  logic [BYTE_W-1:0] opnd1,
  input  logic              undef,
  output logic [2:0]        cls,
  output logic [3:0]        bitnum,
  output logic [3:0]        cond,
  output logic [1:0]        amode,
  output logic [2:0]        sub,
  output logic [1:0]        extkind
);
  logic [3:0] nib;
  logic [3:0] hi;
  logic [3:0] onib;
  logic       is_pfx;
  logic       is_bit;
  logic       is_jmp;
  logic       has_am;

  assign nib    = op[3:0];
  assign hi     = op[7:4];
  assign onib   = opnd1[3:0];
  assign is_pfx = (op == 8'hD1) || (op == 8'hD7) || (op == 8'hDC);
  assign is_bit = (nib == 4'hE) || (nib == 4'hF);
  assign is_jmp = (nib == 4'hD);
  assign has_am = !op[7] && (nib[3:1] == 3'b100);

  always_comb begin
    if (undef)                           cls = CLS_OTHER;
    else if (is_pfx)                     cls = CLS_PFX;
    else if (is_bit)                     cls = CLS_BIT;
    else if (is_jmp)                     cls = CLS_JMP;
    else if (!op[7] && nib <= 4'h9)      cls = CLS_ALU;
    else                                 cls = CLS_OTHER;
  end

  assign bitnum  = is_bit ? hi : 4'h0;
  assign cond    = is_jmp ? hi : 4'h0;
  assign extkind = is_pfx ? opnd1[7:6] : 2'b00;

  always_comb begin
    amode = AM_NONE;
    sub   = 3'd0;
    if (has_am) begin
      if (!onib[3]) begin
        amode = AM_IMM;
        sub   = onib[2:0];
      end else begin
        amode = onib[2] ? AM_INC : AM_IND;
        sub   = {1'b0, onib[1:0]};
      end
    end
  end
endmodule

// File: rtl/ibs_assemble.sv
module ibs_assemble
  import ibs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              op_long4,
  input  logic              op_undef,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_opcode,
  output logic [LEN_W-1:0]  out_len,
  output logic [OPND_W-1:0] out_operand,
  output logic              out_trap
);
  logic [CNT_W-1:0]  cnt_q;
  logic              long_q;
  logic              undef_q;
  logic [BYTE_W-1:0] op_q;
  logic [BYTE_W-1:0] b1_q;
  logic [BYTE_W-1:0] b2_q;
  logic              accept;

  assign in_ready = !flush && !(out_valid && !out_ready);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      long_q      <= 1'b0;
      undef_q     <= 1'b0;
      op_q        <= '0;
      b1_q        <= '0;
      b2_q        <= '0;
      out_valid   <= 1'b0;
      out_opcode  <= '0;
      out_len     <= '0;
      out_operand <= '0;
      out_trap    <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (flush) begin
        cnt_q <= '0;
      end else if (accept) begin
        unique case (cnt_q)
          2'd0: begin
            op_q    <= in_byte;
            long_q  <= op_long4 && !op_undef;
            undef_q <= op_undef;
            cnt_q   <= 2'd1;
          end
          2'd1: begin
            if (long_q) begin
              b1_q  <= in_byte;
              cnt_q <= 2'd2;
            end else begin
              out_valid   <= 1'b1;
              out_opcode  <= op_q;
              out_len     <= LEN_W'(2);
              out_operand <= {{(OPND_W-BYTE_W){1'b0}}, in_byte};
              out_trap    <= undef_q;
              cnt_q       <= 2'd0;
            end
          end
          2'd2: begin
            b2_q  <= in_byte;
            cnt_q <= 2'd3;
          end
          default: begin
            out_valid   <= 1'b1;
            out_opcode  <= op_q;
            out_len     <= LEN_W'(MAX_LEN);
            out_operand <= {in_byte, b2_q, b1_q};
            out_trap    <= 1'b0;
            cnt_q       <= 2'd0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ibs_predecode.sv
module ibs_predecode
  import ibs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_opcode,
  output logic [2:0]  out_len,
  output logic [23:0] out_operand,
  output logic        out_trap,
  output logic [2:0]  out_class,
  output logic [3:0]  out_bitnum,
  output logic [3:0]  out_cond,
  output logic [1:0]  out_amode,
  output logic [2:0]  out_sub,
  output logic [1:0]  out_extkind
);
  logic op_long4;
  logic op_undef;

  ibs_len_map u_len (
    .op    (in_byte),
    .long4 (op_long4),
    .undef (op_undef)
  );

  ibs_assemble u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_byte     (in_byte),
    .op_long4    (op_long4),
    .op_undef    (op_undef),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_opcode  (out_opcode),
    .out_len     (out_len),
    .out_operand (out_operand),
    .out_trap    (out_trap)
  );

  ibs_field_dec u_fld (
    .op      (out_opcode),
    .opnd1   (out_operand[7:0]),
    .undef   (out_trap),
    .cls     (out_class),
    .bitnum  (out_bitnum),
    .cond    (out_cond),
    .amode   (out_amode),
    .sub     (out_sub),
    .extkind (out_extkind)
  );
endmodule

// File: rtl/ibs_predecode_chk.sv
module ibs_predecode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_opcode,
  input logic [2:0]  out_len,
  input logic [23:0] out_operand,
  input logic        out_trap,
  input logic [2:0]  out_class,
  input logic [3:0]  out_bitnum,
  input logic [3:0]  out_cond,
  input logic [1:0]  out_extkind
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_operand)
      && $stable(out_len) && $stable(out_trap)); // R10
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10
  AST_FLUSH_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready); // R11
  AST_LEGAL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len == 3'd2 || out_len == 3'd4)); // R1
  AST_TRAP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trap |-> out_len == 3'd2 && out_class == 3'd4); // R3
  AST_BIT_NUMBER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_opcode[3:1] == 3'b111 |-> out_bitnum == out_opcode[7:4]); // R4
  AST_JUMP_COND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_opcode[3:0] == 4'hD |-> out_cond == out_opcode[7:4]); // R5
  AST_PREFIX_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_opcode == 8'hD7 |-> out_extkind == out_operand[7:6]); // R8
  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_len == 3'd2 |-> out_operand[23:8] == 16'h0); // R10
endmodule

bind ibs_predecode ibs_predecode_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_opcode  (out_opcode),
  .out_len     (out_len),
  .out_operand (out_operand),
  .out_trap    (out_trap),
  .out_class   (out_class),
  .out_bitnum  (out_bitnum),
  .out_cond    (out_cond),
  .out_extkind (out_extkind)
);

// File: tb/ibs_predecode_tb.sv
module ibs_predecode_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_opcode;
  logic [2:0]  out_len;
  logic [23:0] out_operand;
  logic        out_trap;
  logic [2:0]  out_class;
  logic [3:0]  out_bitnum;
  logic [3:0]  out_cond;
  logic [1:0]  out_amode;
  logic [2:0]  out_sub;
  logic [1:0]  out_extkind;

  always #(CLK_PERIOD/2) clk = ~clk;

  ibs_predecode u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .out_valid(out_valid),
    .out_ready(out_ready), .out_opcode(out_opcode), .out_len(out_len),
    .out_operand(out_operand), .out_trap(out_trap), .out_class(out_class),
    .out_bitnum(out_bitnum), .out_cond(out_cond), .out_amode(out_amode),
    .out_sub(out_sub), .out_extkind(out_extkind)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [2:0]  len;
    logic [23:0] opnd;
    logic        trap;
    logic [2:0]  cls;
    logic [3:0]  bitn;
    logic [3:0]  cnd;
    logic [1:0]  am;
    logic [2:0]  sb;
    logic [1:0]  ek;
  } rec_t;

  localparam logic [7:0] LONG_HI [44] = '{
    8'h82, 8'h84, 8'h86, 8'h87, 8'h8A, 8'h92, 8'h94, 8'h96, 8'h97, 8'h9A, 8'hA2,
    8'hA4, 8'hA5, 8'hA6, 8'hA7, 8'hAA, 8'hB2, 8'hB4, 8'hB5, 8'hB6, 8'hB7, 8'hBA,
    8'hC2, 8'hC4, 8'hC5, 8'hC6, 8'hCA, 8'hD2, 8'hD4, 8'hD5, 8'hD6, 8'hD7, 8'hDA,
    8'hE2, 8'hE4, 8'hE6, 8'hE7, 8'hEA, 8'hF2, 8'hF3, 8'hF4, 8'hF6, 8'hF7, 8'hFA};
  localparam logic [7:0] BAD_OPS [20] = '{
    8'h3B, 8'h44, 8'h45, 8'h83, 8'h85, 8'h8B, 8'h8C, 8'h93, 8'h95, 8'hA3,
    8'hB3, 8'hC1, 8'hC3, 8'hC7, 8'hD3, 8'hE3, 8'hE5, 8'hF5, 8'hF8, 8'hF9};

  rec_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  logic bp_mode  = 1'b0;
  logic [7:0] lfsr = 8'hB7;

  task automatic chk(input logic ok, input string tag, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic in_list_long(input logic [7:0] op);
    foreach (LONG_HI[i]) if (LONG_HI[i] == op) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic in_list_bad(input logic [7:0] op);
    foreach (BAD_OPS[i]) if (BAD_OPS[i] == op) return 1'b1;
    return 1'b0;
  endfunction

  function automatic rec_t model(input logic [7:0] op, input logic [7:0] b1,
                                 input logic [7:0] b2, input logic [7:0] b3);
    rec_t r;
    logic [3:0] lo;
    logic is4;
    lo = op[3:0];
    r = '0;
    r.op   = op;
    r.trap = in_list_bad(op);
    if (op < 8'h80) is4 = (lo >= 4'h2 && lo <= 4'h7) || lo == 4'hA;
    else            is4 = in_list_long(op);
    if (r.trap) is4 = 1'b0;
    r.len  = is4 ? 3'd4 : 3'd2;
    r.opnd = is4 ? {b3, b2, b1} : {16'h0, b1};
    if (r.trap)                                        r.cls = 3'd4;
    else if (op == 8'hD1 || op == 8'hD7 || op == 8'hDC) r.cls = 3'd3;
    else if (lo == 4'hE || lo == 4'hF)                 r.cls = 3'd1;
    else if (lo == 4'hD)                               r.cls = 3'd2;
    else if (op < 8'h80 && lo < 4'hA)                  r.cls = 3'd0;
    else                                               r.cls = 3'd4;
    if (lo == 4'hE || lo == 4'hF) r.bitn = op[7:4];
    if (lo == 4'hD) r.cnd = op[7:4];
    if (op == 8'hD1 || op == 8'hD7 || op == 8'hDC) r.ek = b1[7:6];
    if (op < 8'h80 && (lo == 4'h8 || lo == 4'h9)) begin
      if (b1[3:0] < 4'h8)       begin r.am = 2'd1; r.sb = b1[2:0]; end
      else if (b1[3:0] < 4'hC)  begin r.am = 2'd2; r.sb = 3'(b1[3:0] - 4'h8); end
      else                      begin r.am = 2'd3; r.sb = 3'(b1[3:0] - 4'hC); end
    end
    return r;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    logic took;
    in_valid = 1'b1;
    in_byte  = b;
    took = 1'b0;
    while (!took) begin
      #(CLK_PERIOD/2 - 1);
      took = in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic send_instr(input logic [7:0] op, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3);
    rec_t r;
    r = model(op, b1, b2, b3);
    exp_q.push_back(r);
    send_byte(op);
    send_byte(b1);
    if (r.len == 3'd4) begin
      send_byte(b2);
      send_byte(b3);
    end
  endtask

  // monitor: drive out_ready at negedge, sample just before the next edge
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = bp_mode ? (lfsr[0] & lfsr[2]) : 1'b1;
      #(CLK_PERIOD/2 - 1);
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected record opcode", out_opcode, 0);
        end else begin
          rec_t e;
          e = exp_q.pop_front();
          chk(out_opcode == e.op, "R10", "opcode order", out_opcode, e.op);
          chk(out_len == e.len, e.op[7] ? "R2" : "R1", "length", out_len, e.len);
          chk(out_trap == e.trap, "R3", "trap flag", out_trap, e.trap);
          chk(out_class == e.cls, "R9", "class", out_class, e.cls);
          chk(out_bitnum == e.bitn, "R4", "bit number", out_bitnum, e.bitn);
          chk(out_cond == e.cnd, "R5", "condition", out_cond, e.cnd);
          chk(out_amode == e.am, (e.am == 2'd1) ? "R6" : "R7", "addr mode", out_amode, e.am);
          chk(out_sub == e.sb, (e.am == 2'd1) ? "R6" : "R7", "sub value", out_sub, e.sb);
          chk(out_extkind == e.ek, "R8", "prefix kind", out_extkind, e.ek);
          chk(out_operand == e.opnd, "R10", "operand bytes", out_operand, e.opnd);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "R10", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  task automatic sweep(input int salt);
    for (int op = 0; op < 256; op++)
      send_instr(8'(op), 8'(op * 37 + salt), 8'(~op), 8'(op ^ 8'hA5));
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/2 - 1);
    // R12 reset state
    chk(out_valid == 1'b0, "R12", "out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #(CLK_PERIOD/2 - 1);
    chk(out_valid == 1'b0, "R12", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R12", "in_ready after reset", in_ready, 1);
    @(negedge clk);

    // R1 R2 R3 R4 R5 R9: every opcode, no back-pressure
    sweep(11);
    // R6 R7: all sixteen operand nibbles on two mode-carrying opcodes
    for (int n = 0; n < 16; n++) begin
      send_instr(8'h28, 8'(8'h30 + n), 8'h00, 8'h00);
      send_instr(8'h79, 8'(8'hF0 + n), 8'h00, 8'h00);
    end
    // R8: each prefix kind on every prefix opcode
    for (int k = 0; k < 4; k++) begin
      send_instr(8'hD1, 8'(k * 64 + 5), 8'h00, 8'h00);
      send_instr(8'hD7, 8'(k * 64 + 9), 8'h12, 8'h34);
      send_instr(8'hDC, 8'(k * 64 + 3), 8'h00, 8'h00);
    end
    // R3: back-to-back undefined opcodes, resume alignment after each pair
    send_instr(8'h44, 8'h86, 8'h00, 8'h00);
    send_instr(8'hF8, 8'hF9, 8'h00, 8'h00);
    send_instr(8'h86, 8'h11, 8'h22, 8'h33);
    drain();

    // R10: irregular back-pressure over the full map
    bp_mode = 1'b1;
    sweep(90);
    drain();
    bp_mode = 1'b0;
    @(negedge clk);

    // R11: flush after three bytes of a long instruction
    send_byte(8'h06);
    send_byte(8'hAA);
    send_byte(8'hBB);
    flush = 1'b1;
    #(CLK_PERIOD/2 - 1);
    chk(in_ready == 1'b0, "R11", "in_ready during flush", in_ready, 0);
    @(negedge clk);
    flush = 1'b0;
    send_instr(8'h0D, 8'h05, 8'h00, 8'h00);
    // R11: flush after only the opcode byte
    send_byte(8'hE6);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    send_instr(8'h5F, 8'h40, 8'h00, 8'h00);
    drain();
    repeat (4) @(negedge clk);
    #(CLK_PERIOD/2 - 1);
    chk(exp_q.size() == 0, "R10", "records missing", exp_q.size(), 0);
    chk(out_valid == 1'b0, "R11", "stray record after flush", out_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule